// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed station-management master for clause 22 PHY access. Software describes a transaction through a small register set: a command register holding the PHY address, the PHY register number and a read/write selector, a write-data register, and a control register. Writing the control register with both the enable and start bits set launches one serial frame on the management clock and data lines. The frame engine serialises the whole frame, releases the data line for the turnaround and data field of a read, and captures the returned 16-bit word.

The control register's status bit is owned by hardware. It reads 1 from the clock edge that accepts the start until the edge that ends the frame, and a poll that sees it at 0 may read the result at once. The management clock is the system clock divided by the `CLK_DIV` parameter. The clock runs only while a frame is in flight and is held low otherwise. The data line leaves the block as separate output, output-enable and input pins, so the pad or tri-state buffer can sit at chip level.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command register sits at byte offset 0x7E4. Bits [4:0] hold the PHY register number, bits [9:5] the PHY address and bit 10 the operation (1 = read, 0 = write). Bits above 10 read back as 0.
- R2: The write-data register sits at 0x7E8 and keeps only bits [15:0]. The read-data register sits at 0x7EC and returns the last captured word in bits [15:0]. Register reads return data one cycle after the request.
- R3: A write to the control register at 0x7F0 that has bit 3 (enable) and bit 0 (start/status) both set starts a frame while the block is idle. Status then reads 1.
- R4: The status bit returns to 0 exactly 64 x CLK_DIV clock cycles after the edge that accepted the start.
- R5: A control write with bit 0 set and bit 3 clear starts nothing. MDC stays low and status stays 0.
- R6: A write frame puts these bits on the data output, most significant bit first, and holds each bit steady around the MDC rising edge: 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the 16 write-data bits.
- R7: A read frame uses opcode 10. It drives the output enable only for the first 46 bits, then releases the line and samples mdio_in on 16 MDC rising edges. The sampled word, first sample most significant, lands in the read-data register.
- R8: A read with mdio_in held high, as when no PHY answers, returns 0xFFFF.
- R9: A start write during a frame has no effect. The frame's bits and its end time do not change.
- R10: MDC is low while idle. During a frame its period is CLK_DIV system clocks, with CLK_DIV/2 high and CLK_DIV/2 low, giving 64 rising edges per frame.
- R11: The control register reads bit 3 as the last written enable value and bit 0 as the status. All other bits read 0.
- R12: After reset all registers read 0, and mdc and mdio_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset of the register |
| bus_wdata | input | BUS_DW | Write data |
| bus_rdata | output | BUS_DW | Read data, valid the cycle after a read request |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data to the pad |
| mdio_oe | output | 1 | Pad drive enable |
| mdio_in | input | 1 | Serial data from the pad |

## Verification
Register read data is due one cycle after the request. The bench always samples it at the following falling clock edge. The end of a frame has a fixed latency of 64 x CLK_DIV cycles from the start edge. The bench reads status at the last busy cycle and at the first idle cycle, so a one-cycle shift in either direction is caught, and it reads the captured word in that same idle window. Serial bits are compared one by one at each MDC rising edge against a queue filled before the start, and each MDC period is timed against CLK_DIV.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PHY_AW   = 5;
  localparam int REG_NW   = 5;
  localparam int DATA_W   = 16;
  localparam int PRE_LEN  = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_AW + REG_NW + 2 + DATA_W;
  localparam int RD_DRIVE_LEN = FRAME_LEN - DATA_W - 2;

  localparam int CTRL_BUSY_BIT = 0;
  localparam int CTRL_EN_BIT   = 3;

  localparam logic [11:0] OFS_CMD   = 12'h7E4;
  localparam logic [11:0] OFS_WDATA = 12'h7E8;
  localparam logic [11:0] OFS_RDATA = 12'h7EC;
  localparam logic [11:0] OFS_CTRL  = 12'h7F0;

  typedef struct packed {
    logic              rd;
    logic [PHY_AW-1:0] phy;
    logic [REG_NW-1:0] regn;
  } mdio_cmd_t;

  localparam int CMD_W = $bits(mdio_cmd_t);

  function automatic logic [FRAME_LEN-1:0] build_frame(mdio_cmd_t c, logic [DATA_W-1:0] d);
    logic [1:0] opc;
    logic [1:0] ta;
    logic [DATA_W-1:0] dd;
    opc = c.rd ? 2'b10 : 2'b01;
    ta  = c.rd ? 2'b11 : 2'b10;
    dd  = c.rd ? {DATA_W{1'b1}} : d;
    return {{PRE_LEN{1'b1}}, 2'b01, opc, c.phy, c.regn, ta, dd};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic edge_now;

  generate
    if (HALF > 1) begin : g_cnt
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run)                 cnt <= '0;
        else if (cnt == CW'(HALF - 1))   cnt <= '0;
        else                             cnt <= cnt + 1'b1;
      end
      assign edge_now = run && (cnt == CW'(HALF - 1));
    end else begin : g_fast
      assign edge_now = run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run)   mdc <= 1'b0;
    else if (edge_now) mdc <= ~mdc;
  end

  assign rise_stb = edge_now && !mdc;
  assign fall_stb = edge_now && mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_in,
  output logic              busy,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_word
);
  localparam int IW = $clog2(FRAME_LEN);
  localparam logic [IW-1:0] LAST_BIT   = IW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] DATA_FIRST = IW'(FRAME_LEN - DATA_W);
  localparam logic [IW-1:0] LAST_DRIVE = IW'(RD_DRIVE_LEN - 1);

  logic [FRAME_LEN-1:0] next_frame;
  logic [FRAME_LEN-2:0] shreg;
  logic [IW-1:0]        bit_idx;
  logic                 is_rd;
  logic [DATA_W-1:0]    rd_sh;

  assign next_frame = build_frame(cmd, wr_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b0;
      shreg    <= '1;
      bit_idx  <= '0;
      is_rd    <= 1'b0;
      rd_sh    <= '0;
      rd_word  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        mdio_out <= next_frame[FRAME_LEN-1];
        shreg    <= next_frame[FRAME_LEN-2:0];
        mdio_oe  <= 1'b1;
        bit_idx  <= '0;
        is_rd    <= cmd.rd;
      end
    end else begin
      if (rise_stb && is_rd && bit_idx >= DATA_FIRST)
        rd_sh <= {rd_sh[DATA_W-2:0], mdio_in};
      if (fall_stb) begin
        if (bit_idx == LAST_BIT) begin
          busy     <= 1'b0;
          mdio_oe  <= 1'b0;
          mdio_out <= 1'b1;
          if (is_rd) rd_word <= rd_sh;
        end else begin
          bit_idx  <= bit_idx + 1'b1;
          mdio_out <= shreg[FRAME_LEN-2];
          shreg    <= {shreg[FRAME_LEN-3:0], 1'b1};
          if (is_rd && bit_idx == LAST_DRIVE) mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int BUS_AW = 12,
  parameter int BUS_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output mdio_cmd_t         cmd,
  output logic [DATA_W-1:0] wr_word,
  output logic              start
);
  localparam logic [BUS_AW-1:0] A_CMD   = BUS_AW'(OFS_CMD);
  localparam logic [BUS_AW-1:0] A_WDATA = BUS_AW'(OFS_WDATA);
  localparam logic [BUS_AW-1:0] A_RDATA = BUS_AW'(OFS_RDATA);
  localparam logic [BUS_AW-1:0] A_CTRL  = BUS_AW'(OFS_CTRL);

  logic en_q;
  logic wr_ctrl;
  logic [BUS_DW-1:0] rd_mux;

  assign wr_ctrl = bus_req && bus_we && (bus_addr == A_CTRL);
  assign start   = wr_ctrl && bus_wdata[CTRL_EN_BIT] && bus_wdata[CTRL_BUSY_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd     <= '0;
      wr_word <= '0;
      en_q    <= 1'b0;
    end else if (bus_req && bus_we) begin
      if (bus_addr == A_CMD)   cmd     <= mdio_cmd_t'(bus_wdata[CMD_W-1:0]);
      if (bus_addr == A_WDATA) wr_word <= bus_wdata[DATA_W-1:0];
      if (wr_ctrl)             en_q    <= bus_wdata[CTRL_EN_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CMD)   rd_mux[CMD_W-1:0]  = cmd;
    if (bus_addr == A_WDATA) rd_mux[DATA_W-1:0] = wr_word;
    if (bus_addr == A_RDATA) rd_mux[DATA_W-1:0] = rd_word;
    if (bus_addr == A_CTRL) begin
      rd_mux[CTRL_EN_BIT]   = en_q;
      rd_mux[CTRL_BUSY_BIT] = busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_req && !bus_we) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 40,
  parameter int BUS_AW  = 12,
  parameter int BUS_DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  mdio_cmd_t         cmd;
  logic [DATA_W-1:0] wr_word;
  logic [DATA_W-1:0] rd_word;
  logic              start;
  logic              eng_busy;
  logic              rise_stb;
  logic              fall_stb;

  mdio_regs #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(eng_busy), .rd_word(rd_word),
    .cmd(cmd), .wr_word(wr_word), .start(start)
  );

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk(clk), .rst(rst), .run(eng_busy),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .wr_word(wr_word),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_in(mdio_in),
    .busy(eng_busy), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rd_word(rd_word)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 40,
  parameter int BUS_AW  = 12,
  parameter int BUS_DW  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic              mdc,
  input logic              mdio_oe,
  input logic              busy
);
  localparam int FRAME_CYC = FRAME_LEN * CLK_DIV;
  localparam int CNT_W     = $clog2(FRAME_CYC + 1);

  logic [CNT_W-1:0] busy_cyc;
  logic ctrl_go;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cyc <= '0;
    else              busy_cyc <= busy_cyc + 1'b1;
  end

  assign ctrl_go = bus_req && bus_we && (bus_addr == BUS_AW'(OFS_CTRL))
                   && bus_wdata[CTRL_EN_BIT] && bus_wdata[CTRL_BUSY_BIT];

  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy); // R7
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc); // R10
  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctrl_go)); // R5
  AST_END_ON_MDC_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $fell(mdc)); // R10
  AST_FRAME_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cyc <= CNT_W'(FRAME_CYC - 1))); // R4
  AST_FRAME_EXACT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(busy_cyc) == CNT_W'(FRAME_CYC - 1))); // R4
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(
  .CLK_DIV(CLK_DIV), .BUS_AW(BUS_AW), .BUS_DW(BUS_DW)
) u_mdio_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .mdc(mdc), .mdio_oe(mdio_oe), .busy(eng_busy)
);

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/100ps
module test_mdio_mgmt_master;
  localparam int CLK_DIV = 8;
  localparam int FCYC    = 64 * CLK_DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int failures = 0;
  int edge_n = 0;
  bit exp_q[$];
  string cur_tag = "R6";
  logic [15:0] phy_data = '0;
  bit phy_present = 1'b0;
  real last_rise = 0.0;

  always #2.5 clk = ~clk;

  mdio_mgmt_master #(.CLK_DIV(CLK_DIV)) i_mdio_mgmt_master (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  // driver side of the scoreboard: expected driven bits, MSB first
  task automatic push_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rn,
                            input logic [15:0] d, input string tag);
    logic [63:0] pat;
    int n;
    pat = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rn, 2'b10, d};
    n = rd ? 46 : 64;
    exp_q.delete();
    for (int i = 63; i > 63 - n; i--) exp_q.push_back(pat[i]);
    cur_tag = tag;
    edge_n = 0;
  endtask

  // monitor: compare each driven bit at the MDC rising edge
  initial begin
    forever begin
      @(posedge mdc);
      #1;
      edge_n++;
      if (edge_n >= 2) chk("R10 period", int'($realtime - last_rise), CLK_DIV * 5);
      last_rise = $realtime;
      if (mdio_oe) begin
        if (exp_q.size() == 0) chk({cur_tag, " extra driven bit"}, 1, 0);
        else chk({cur_tag, " bit"}, {31'b0, mdio_out}, {31'b0, exp_q.pop_front()});
      end
    end
  end

  // PHY model: present the next data bit after each MDC fall
  initial begin
    forever begin
      @(negedge mdc);
      if (phy_present && edge_n >= 48 && edge_n <= 63) mdio_in = phy_data[63 - edge_n];
      else mdio_in = 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 mdc", {31'b0, mdc}, 0);
    chk("R12 oe", {31'b0, mdio_oe}, 0);
    bus_rd(12'h7E4, v); chk("R12 cmd", v, 0);
    bus_rd(12'h7E8, v); chk("R12 wdata", v, 0);
    bus_rd(12'h7EC, v); chk("R12 rdata", v, 0);
    bus_rd(12'h7F0, v); chk("R12 ctrl", v, 0);

    // R1 field layout
    bus_wr(12'h7E4, 32'hFFFF_FFFF);
    bus_rd(12'h7E4, v); chk("R1 mask", v, 32'h7FF);
    bus_wr(12'h7E4, 32'h6AA);
    bus_rd(12'h7E4, v); chk("R1 fields", v, 32'h6AA);

    // R2 write-data width
    bus_wr(12'h7E8, 32'hABCD_1234);
    bus_rd(12'h7E8, v); chk("R2 wdata", v, 32'h1234);

    // R5 start without enable
    edge_n = 0;
    bus_wr(12'h7F0, 32'h1);
    repeat (30) @(negedge clk);
    chk("R5 no mdc", edge_n, 0);
    bus_rd(12'h7F0, v); chk("R5 ctrl", v, 0);

    // R6 write frame, R4 end time
    bus_wr(12'h7E4, 32'h224);
    bus_wr(12'h7E8, 32'hBEEF);
    push_frame(1'b0, 5'h11, 5'h04, 16'hBEEF, "R6");
    bus_wr(12'h7F0, 32'h9);
    repeat (FCYC - 1) @(negedge clk);
    bus_rd(12'h7F0, v); chk("R4 last busy", v, 32'h9);
    bus_rd(12'h7F0, v); chk("R4 idle R11", v, 32'h8);
    chk("R6 all bits", exp_q.size(), 0);
    chk("R10 edges", edge_n, 64);

    // R7 read frame with R9 second start during the frame
    bus_wr(12'h7E4, 32'h462);
    phy_present = 1'b1; phy_data = 16'h5A3C;
    push_frame(1'b1, 5'h03, 5'h02, 16'hFFFF, "R7");
    bus_wr(12'h7F0, 32'h9);
    repeat (100) @(negedge clk);
    bus_wr(12'h7F0, 32'h9);
    repeat (FCYC - 1 - 101) @(negedge clk);
    bus_rd(12'h7F0, v); chk("R9 last busy", v, 32'h9);
    bus_rd(12'h7F0, v); chk("R9 idle", v, 32'h8);
    bus_rd(12'h7EC, v); chk("R7 rdata", v, 32'h5A3C);
    chk("R7 drive count", exp_q.size(), 0);
    chk("R7 released", {31'b0, mdio_oe}, 0);

    // R8 absent PHY, R3 status right after start
    bus_wr(12'h7E4, 32'h7E1);
    phy_present = 1'b0;
    push_frame(1'b1, 5'h1F, 5'h01, 16'hFFFF, "R8");
    bus_wr(12'h7F0, 32'h9);
    bus_rd(12'h7F0, v); chk("R3 status set", v, 32'h9);
    for (int k = 0; k < 2000 && v[0]; k++) bus_rd(12'h7F0, v);
    chk("R8 done", v, 32'h8);
    bus_rd(12'h7EC, v); chk("R8 rdata", v, 32'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule